// File: doc/BRIEF.md
# NAND Bus Strobe Timing Generator

This block turns byte-level requests into the pin-level strobe sequence of a NAND flash bus. A request carries a kind: command, address, data write or data read. The block then moves through a set of phases: an optional bus turnaround gap, an optional chip-enable lead time, the low phase of the write or read strobe, and the high phase of that strobe. Each phase lasts a number of host clock cycles taken from one packed timing word. When the high phase ends, the block pulses a completion flag and returns to idle. Data reads capture the flash data bus at the end of the read-strobe low phase.

A separate tracker follows the flash ready/busy line. It starts after every write-strobe pulse. It waits a programmable delay before it looks at the line, and it reports the flash as ready only once it has sampled the line released. A small register front end holds the timing word and a chip-enable mode bit. Both registers are write-protected behind a magic unlock value. The protection re-engages after a single protected write.

Top module: `nand_strobe_gen`

## Requirements
- R1: After reset, nand_ce_n, nand_we_n and nand_re_n are 1, nand_cle, nand_ale and nand_doe are 0, and status is 2'b11. The timing word is all zero, the chip-enable mode is normal (1) and the registers are locked.
- R2: A write-type request (kind 0 command, 1 address, 2 data write) drives nand_we_n low for WL+1 cycles and then high for WH+1 cycles, with nand_dout equal to the request byte while the strobe is low. WL is timing bits [3:0] and WH is bits [7:4]. req_done pulses for one cycle in the first cycle after the high phase.
- R3: Kind 0 holds nand_cle high, and kind 1 holds nand_ale high, for exactly the strobe low and high phases together. Kinds 2 and 3 assert neither line.
- R4: A read request (kind 3) drives nand_re_n low for RL+1 cycles and then high for RH+1 cycles, where RL is bits [11:8] and RH is bits [15:12]. nand_din, sampled in the last low cycle, appears on rd_data. nand_we_n and nand_re_n are never low together.
- R5: When a request's direction (read versus write-type) differs from that of the previous accepted request, TA+1 cycles pass before the request starts, with every strobe and latch line inactive. TA is bits [18:16]. The previous direction after reset counts as write. No gap is added when the direction is the same.
- R6: With chip-enable mode 1, nand_ce_n goes low CEA+1 cycles before the strobe low phase and returns high when the request completes. CEA is bits [25:24]. With mode 0, nand_ce_n stays low at all times and no lead time is added.
- R7: Status bit 0 (flash ready) drops when the write strobe rises and stays low for BD+1 cycles, where BD is bits [23:19]. After that it stays low until nand_rb_n is sampled high, and it goes high in the cycle after that sample.
- R8: Status bit 1 (controller ready) is low from the cycle after a request is accepted until the completion cycle. A request presented while it is low is ignored.
- R9: A register write with reg_sel 1 (timing word, bits [25:0]) or reg_sel 2 (chip-enable mode, bit 0) takes effect only if the latest lock write (reg_sel 0) carried 32'h0000A25E. Otherwise the write is ignored.
- R10: Any write with reg_sel 1 or 2 re-engages the lock. So does a lock write of any value other than the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 lock, 1 timing word, 2 chip-enable mode |
| reg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request valid, taken when controller ready |
| req_kind | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_data | input | 8 | Byte to write |
| req_done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured by the last read |
| status | output | 2 | Bit 1 controller ready, bit 0 flash ready |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dout | output | 8 | Data bus toward the flash |
| nand_doe | output | 1 | Data bus output enable |
| nand_din | input | 8 | Data bus from the flash |
| nand_rb_n | input | 1 | Ready/busy line, low while busy |

## Verification
A phase counter loaded from the wrong field, or off by one, changes the number of cycles a strobe, latch or chip-enable line stays in its state. The bench counts those cycles on every request, so such a fault shows on the first request that uses the field. A stale direction record appears as a turnaround gap that is missing or extra in front of the next request. A lock that fails to re-arm appears as a changed strobe width on the request after an unauthorised register write. A busy tracker that skips its delay or ignores the ready line shows up within one busy window as a wrong count of flash-not-ready cycles, or as a ready bit that rises while the line is still held low.

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen #(
  parameter int DATA_W = 8,
  parameter int REG_W = 32,
  parameter logic [REG_W-1:0] UNLOCK_KEY = 32'h0000_A25E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_done,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        status,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dout,
  output logic              nand_doe,
  input  logic [DATA_W-1:0] nand_din,
  input  logic              nand_rb_n
);
  localparam int TW_W = 26;
  localparam int CNT_W = 4;
  localparam int BCNT_W = 5;

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_CEA, S_LOW, S_HIGH} st_t;
  typedef enum logic [1:0] {B_RDY, B_DLY, B_WAIT} bst_t;

  logic [TW_W-1:0] tword;
  logic            ce_norm;
  logic            unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tword    <= '0;
      ce_norm  <= 1'b1;
      unlocked <= 1'b0;
    end else if (reg_wr) begin
      case (reg_sel)
        2'd0: unlocked <= (reg_wdata == UNLOCK_KEY);
        2'd1: begin
          if (unlocked) tword <= reg_wdata[TW_W-1:0];
          unlocked <= 1'b0;
        end
        2'd2: begin
          if (unlocked) ce_norm <= reg_wdata[0];
          unlocked <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  wire [CNT_W-1:0]  f_wl   = tword[3:0];
  wire [CNT_W-1:0]  f_wh   = tword[7:4];
  wire [CNT_W-1:0]  f_rl   = tword[11:8];
  wire [CNT_W-1:0]  f_rh   = tword[15:12];
  wire [CNT_W-1:0]  f_ta   = {1'b0, tword[18:16]};
  wire [BCNT_W-1:0] f_bd   = tword[23:19];
  wire [CNT_W-1:0]  f_cea  = {2'b00, tword[25:24]};

  st_t              st;
  bst_t             bst;
  logic [CNT_W-1:0] cnt;
  logic [BCNT_W-1:0] bcnt;
  logic [1:0]       kind_q;
  logic [DATA_W-1:0] data_q;
  logic             last_rd;

  wire is_rd  = (kind_q == 2'd3);
  wire req_rd = (req_kind == 2'd3);
  wire accept = req_valid && (st == S_IDLE);
  wire cnt_end = (cnt == '0);
  wire we_rise = (st == S_LOW) && cnt_end && !is_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      kind_q   <= '0;
      data_q   <= '0;
      last_rd  <= 1'b0;
      req_done <= 1'b0;
      rd_data  <= '0;
    end else begin
      req_done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          kind_q  <= req_kind;
          data_q  <= req_data;
          last_rd <= req_rd;
          if (req_rd != last_rd) begin
            st  <= S_TURN;
            cnt <= f_ta;
          end else if (ce_norm) begin
            st  <= S_CEA;
            cnt <= f_cea;
          end else begin
            st  <= S_LOW;
            cnt <= req_rd ? f_rl : f_wl;
          end
        end
        S_TURN: if (cnt_end) begin
          if (ce_norm) begin
            st  <= S_CEA;
            cnt <= f_cea;
          end else begin
            st  <= S_LOW;
            cnt <= is_rd ? f_rl : f_wl;
          end
        end else cnt <= cnt - 1'b1;
        S_CEA: if (cnt_end) begin
          st  <= S_LOW;
          cnt <= is_rd ? f_rl : f_wl;
        end else cnt <= cnt - 1'b1;
        S_LOW: if (cnt_end) begin
          st  <= S_HIGH;
          cnt <= is_rd ? f_rh : f_wh;
          if (is_rd) rd_data <= nand_din;
        end else cnt <= cnt - 1'b1;
        S_HIGH: if (cnt_end) begin
          st       <= S_IDLE;
          req_done <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst  <= B_RDY;
      bcnt <= '0;
    end else if (we_rise) begin
      bst  <= B_DLY;
      bcnt <= f_bd;
    end else begin
      case (bst)
        B_DLY: if (bcnt == '0) bst <= B_WAIT;
               else bcnt <= bcnt - 1'b1;
        B_WAIT: if (nand_rb_n) bst <= B_RDY;
        default: ;
      endcase
    end
  end

  wire in_win = (st == S_LOW) || (st == S_HIGH);
  wire active = in_win || (st == S_CEA);

  assign nand_ce_n = !(!ce_norm || active);
  assign nand_cle  = in_win && (kind_q == 2'd0);
  assign nand_ale  = in_win && (kind_q == 2'd1);
  assign nand_we_n = !((st == S_LOW) && !is_rd);
  assign nand_re_n = !((st == S_LOW) && is_rd);
  assign nand_doe  = in_win && !is_rd;
  assign nand_dout = data_q;
  assign status    = {st == S_IDLE, bst == B_RDY};
endmodule

// File: rtl/nand_strobe_gen_chk.sv
module nand_strobe_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_done,
  input logic [1:0] status,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_rb_n
);
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  // R3
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  // R6
  latch_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cle || nand_ale) |-> !nand_ce_n);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> status[1]);
  // R7
  ready_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(nand_rb_n));
  // R2
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> (nand_we_n && nand_re_n));
endmodule

bind nand_strobe_gen nand_strobe_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_done(req_done), .status(status),
  .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_rb_n(nand_rb_n)
);

// File: tb/nand_strobe_gen_tb.sv
module nand_strobe_gen_tb;
  localparam logic [31:0] KEY = 32'h0000_A25E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [7:0] req_data = '0;
  logic req_done;
  logic [7:0] rd_data;
  logic [1:0] status;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_doe;
  logic [7:0] nand_dout;
  logic [7:0] nand_din = '0;
  logic nand_rb_n = 1'b1;

  always #5 clk = ~clk;

  nand_strobe_gen u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .req_valid(req_valid), .req_kind(req_kind),
    .req_data(req_data), .req_done(req_done), .rd_data(rd_data),
    .status(status), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dout(nand_dout), .nand_doe(nand_doe), .nand_din(nand_din),
    .nand_rb_n(nand_rb_n)
  );

  function automatic logic [25:0] mk(input int wl, input int wh, input int rl,
      input int rh, input int ta, input int bd, input int cea);
    logic [25:0] w;
    w = '0;
    w[3:0] = wl[3:0]; w[7:4] = wh[3:0]; w[11:8] = rl[3:0]; w[15:12] = rh[3:0];
    w[18:16] = ta[2:0]; w[23:19] = bd[4:0]; w[25:24] = cea[1:0];
    return w;
  endfunction

  typedef struct packed {
    logic [25:0] tw;
    logic        ce;
    logic [1:0]  k;
    logic [7:0]  d;
    logic [7:0]  din;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{mk(2,1,0,0,3,4,1),   1'b1, 2'd0, 8'h70, 8'h00},
    '{mk(0,3,0,0,0,0,2),   1'b1, 2'd1, 8'h12, 8'h00},
    '{mk(5,2,0,0,0,7,0),   1'b1, 2'd2, 8'hA5, 8'h00},
    '{mk(0,0,3,2,2,0,3),   1'b1, 2'd3, 8'h00, 8'h3C},
    '{mk(0,0,15,15,1,0,0), 1'b0, 2'd3, 8'h00, 8'hC3},
    '{mk(15,15,0,0,7,31,0),1'b0, 2'd0, 8'hFF, 8'h00},
    '{mk(1,1,1,1,7,2,3),   1'b1, 2'd1, 8'h5A, 8'h00},
    '{mk(3,0,4,0,5,1,1),   1'b1, 2'd3, 8'h00, 8'h81}
  };

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit prev_rd = 0;
  int n_tot, n_lead, n_wl, n_rl, n_cle, n_ale, n_ce, n_bsy, n_cbusy, n_dbad;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic prog(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cfg(input logic [25:0] tw, input logic ce);
    prog(2'd0, KEY); prog(2'd1, {6'd0, tw});
    prog(2'd0, KEY); prog(2'd2, {31'd0, ce});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    prev_rd = 0;
    @(negedge clk);
  endtask

  task automatic run_op(input logic [1:0] k, input logic [7:0] d);
    bit fin, seen;
    int guard;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_data = d;
    n_tot = 0; n_lead = 0; n_wl = 0; n_rl = 0; n_cle = 0; n_ale = 0;
    n_ce = 0; n_bsy = 0; n_cbusy = 0; n_dbad = 0;
    fin = 0; seen = 0; guard = 0;
    @(negedge clk);
    req_valid = 1'b0;
    while (guard < 5000) begin
      if (!fin) begin
        if (req_done) fin = 1;
        else begin
          n_tot++;
          if (!nand_we_n || !nand_re_n) seen = 1;
          if (!seen) n_lead++;
          if (!nand_we_n) n_wl++;
          if (!nand_we_n && nand_dout != d) n_dbad++;
          if (!nand_re_n) n_rl++;
          if (nand_cle) n_cle++;
          if (nand_ale) n_ale++;
          if (!nand_ce_n) n_ce++;
          if (!status[1]) n_cbusy++;
        end
      end
      if (!status[0]) n_bsy++;
      if (fin && status[0]) break;
      @(negedge clk);
      guard++;
    end
    prev_rd = (k == 2'd3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 ce_n", nand_ce_n, 1);
    chk("R1 we_n", nand_we_n, 1);
    chk("R1 re_n", nand_re_n, 1);
    chk("R1 cle|ale|doe", {nand_cle, nand_ale, nand_doe}, 0);
    chk("R1 status", status, 3);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      bit rd;
      int ta_ph, cea_ph, lo, hi, tot;
      v = VT[i];
      cfg(v.tw, v.ce);
      nand_din = v.din;
      rd = (v.k == 2'd3);
      ta_ph  = (rd != prev_rd) ? int'(v.tw[18:16]) + 1 : 0;
      cea_ph = v.ce ? int'(v.tw[25:24]) + 1 : 0;
      lo = rd ? int'(v.tw[11:8]) + 1 : int'(v.tw[3:0]) + 1;
      hi = rd ? int'(v.tw[15:12]) + 1 : int'(v.tw[7:4]) + 1;
      tot = ta_ph + cea_ph + lo + hi;
      run_op(v.k, v.d);
      chk($sformatf("R2/R4 v%0d total", i), n_tot, tot);
      chk($sformatf("R5/R6 v%0d lead", i), n_lead, ta_ph + cea_ph);
      chk($sformatf("R2 v%0d we low", i), n_wl, rd ? 0 : lo);
      chk($sformatf("R2 v%0d dout", i), n_dbad, 0);
      chk($sformatf("R4 v%0d re low", i), n_rl, rd ? lo : 0);
      chk($sformatf("R3 v%0d cle", i), n_cle, (v.k == 2'd0) ? lo + hi : 0);
      chk($sformatf("R3 v%0d ale", i), n_ale, (v.k == 2'd1) ? lo + hi : 0);
      chk($sformatf("R6 v%0d ce low", i), n_ce, v.ce ? cea_ph + lo + hi : tot);
      chk($sformatf("R7 v%0d busy", i), n_bsy, rd ? 0 : int'(v.tw[23:19]) + 2);
      chk($sformatf("R8 v%0d ctrl busy", i), n_cbusy, tot);
      if (rd) chk($sformatf("R4 v%0d rd_data", i), rd_data, v.din);
      chk($sformatf("R6 v%0d idle ce_n", i), nand_ce_n, v.ce ? 1 : 0);
    end

    // R9 locked writes ignored
    do_reset();
    chk("R1 status after reset", status, 3);
    prog(2'd1, {6'd0, mk(5,5,0,0,0,0,3)});
    prog(2'd2, 32'd0);
    run_op(2'd0, 8'h90);
    chk("R9 total", n_tot, 3);
    chk("R9 we low", n_wl, 1);
    chk("R9 idle ce_n", nand_ce_n, 1);

    // R10 relock after one protected write
    prog(2'd0, KEY);
    prog(2'd1, {6'd0, mk(3,0,0,0,0,0,0)});
    prog(2'd1, {6'd0, mk(9,0,0,0,0,0,0)});
    run_op(2'd0, 8'h01);
    chk("R10 second write ignored", n_wl, 4);
    prog(2'd0, 32'h0000_A25F);
    prog(2'd1, {6'd0, mk(7,0,0,0,0,0,0)});
    run_op(2'd0, 8'h02);
    chk("R9 wrong key ignored", n_wl, 4);
    prog(2'd0, KEY);
    prog(2'd0, 32'h0000_1234);
    prog(2'd1, {6'd0, mk(11,0,0,0,0,0,0)});
    run_op(2'd0, 8'h03);
    chk("R10 lock rewritten", n_wl, 4);
    prog(2'd0, KEY);
    prog(2'd1, {6'd0, mk(6,0,0,0,0,0,0)});
    run_op(2'd0, 8'h04);
    chk("R9 key accepted", n_wl, 7);

    // R8 request while controller busy is ignored
    cfg(mk(10,2,0,0,0,0,0), 1'b1);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd0; req_data = 8'h55;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 busy during op", status[1], 0);
    req_valid = 1'b1; req_kind = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    begin
      int g = 0;
      while (!req_done && g < 100) begin @(negedge clk); g++; end
    end
    begin
      int strobes = 0;
      int notready = 0;
      for (int j = 0; j < 12; j++) begin
        @(negedge clk);
        if (!nand_we_n || !nand_re_n) strobes++;
        if (!status[1]) notready++;
      end
      chk("R8 ignored request strobes", strobes, 0);
      chk("R8 ignored request ready", notready, 0);
    end

    // R7 busy held by ready/busy line
    cfg(mk(0,0,0,0,0,2,0), 1'b1);
    nand_rb_n = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd0; req_data = 8'h60;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7 held busy", status[0], 0);
    nand_rb_n = 1'b1;
    @(negedge clk);
    chk("R7 released", status[0], 1);

    summary();
  end
endmodule